// File: doc/BRIEF.md
# Shared-Pin Serial Configuration Loader

This block receives a 20-bit configuration word from an external controller over two wires: a serial clock line and a data line. The data line is shared. In normal operation the chip drives it as an output, so the loader must release it whenever the controller needs it. Both wires are oversampled by the system clock through a two-flop synchronizer. Framing markers are formed by toggling the data line while the serial clock is high. Ordinary data bits change only while the serial clock is low.

A transfer opens with a start marker. The controller lowers and then raises the serial clock while data is low, and then pulses data high and back low while the clock stays high. Bits then follow, most significant first. A stop marker closes the transfer: with the clock high, data pulses high and back low, and then the clock falls. The stop is the moment the shifted bits are written into the register. A short transfer of N bits rewrites only the N least significant bits. If the serial clock does not move for 200 µs, the transfer is dropped and the register keeps its old value.

Top module: `cfg_pin_loader`

## Requirements
- R1: After reset the register holds DEFAULT_CFG (20'h5A5A5 by default). The programming flag is low. The data-pin output enable is high while the serial clock is low.
- R2: The output enable is low whenever the synchronized serial clock is high, and whenever a transfer is in progress. It is high only when idle with the serial clock low.
- R3: A complete start marker raises the programming flag.
- R4: A 20-bit transfer sent most significant bit first replaces the whole register. The last bit before the stop becomes bit 0.
- R5: A transfer of N bits (0 ≤ N < 20) rewrites bits N-1..0 only. All higher bits keep their values, and N = 0 changes nothing.
- R6: The register does not change before the stop marker completes. After the serial clock falls at the end of the stop, the programming flag is low and the output enable is high again.
- R7: If no serial clock edge occurs for 200 µs of system clock (10000 cycles at 50 MHz) during a transfer or a marker, the loader returns to idle. No bits are committed.
- R8: A transfer longer than 20 bits keeps only the last 20 bits received.
- R9: A start marker that is cut short, with the serial clock falling before the data pulse ends, does not raise the programming flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_pin_i | input | 1 | Serial clock line |
| sdat_pin_i | input | 1 | Data line, pad input side |
| sdat_oe_o | output | 1 | Output enable for the shared data pad |
| prog_active_o | output | 1 | High while a transfer is open |
| cfg_o | output | 20 | Configuration register contents |

## Verification
The commit path is tried with full-width words of mixed, all-zero and all-one bits. These tell apart bit order and a stuck or dropped position. Partial lengths of 0, 1, 3, 8 and 12 bits show whether the upper bits are protected and whether the write mask is off by one. An over-long 24-bit burst shows whether the shifter keeps the newest bits or the oldest. A cut-short start marker and a transfer abandoned by a stalled serial clock each show whether framing errors leave the register and the pin direction untouched.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_SOPEN = 3'd2,
    ST_SHIFT = 3'd3,
    ST_MARK  = 3'd4,
    ST_FIN   = 3'd5
  } ld_state_t;
endpackage

// File: rtl/cfgl_pin_sync.sv
module cfgl_pin_sync #(
  parameter int N_LINES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pin_i,
  output logic [N_LINES-1:0] lvl_o,
  output logic [N_LINES-1:0] rise_o,
  output logic [N_LINES-1:0] fall_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic s0, s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s0 <= 1'b0;
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s0 <= pin_i[g];
        s1 <= s0;
        s2 <= s1;
      end
    end
    assign lvl_o[g]  = s1;
    assign rise_o[g] = s1 & ~s2;
    assign fall_o[g] = ~s1 & s2;
  end
endmodule

// File: rtl/cfgl_seq_fsm.sv
module cfgl_seq_fsm
  import cfgl_pkg::*;
#(
  parameter int TIMEOUT_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ck_lvl_i,
  input  logic ck_rise_i,
  input  logic ck_fall_i,
  input  logic d_lvl_i,
  input  logic d_rise_i,
  input  logic d_fall_i,
  output logic take_o,
  output logic take_bit_o,
  output logic clear_o,
  output logic commit_o,
  output logic active_o,
  output logic idle_o
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

  ld_state_t state_q, state_d;
  logic pend_v_q, pend_b_q;
  logic [TMR_W-1:0] tmr_q;
  logic evt_timeout;
  logic ck_edge;

  assign ck_edge     = ck_rise_i | ck_fall_i;
  assign evt_timeout = (state_q != ST_IDLE) && !ck_edge &&
                       (tmr_q == TMR_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else if (state_q == ST_IDLE || ck_edge) tmr_q <= '0;
    else tmr_q <= tmr_q + 1'b1;
  end

  always_comb begin
    state_d    = state_q;
    take_o     = 1'b0;
    take_bit_o = pend_b_q;
    clear_o    = 1'b0;
    commit_o   = 1'b0;
    if (evt_timeout) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (ck_rise_i && !d_lvl_i) state_d = ST_ARM;
        ST_ARM: begin
          if (ck_fall_i) state_d = ST_IDLE;
          else if (d_rise_i) state_d = ST_SOPEN;
        end
        ST_SOPEN: begin
          if (ck_fall_i) state_d = ST_IDLE;
          else if (d_fall_i) begin
            state_d = ST_SHIFT;
            clear_o = 1'b1;
          end
        end
        ST_SHIFT: begin
          if (ck_fall_i) take_o = pend_v_q;
          else if (d_rise_i && ck_lvl_i) state_d = ST_MARK;
        end
        ST_MARK: begin
          if (ck_fall_i) state_d = ST_IDLE;
          else if (d_fall_i) state_d = ST_FIN;
        end
        ST_FIN: begin
          if (ck_fall_i) begin
            state_d  = ST_IDLE;
            commit_o = 1'b1;
          end else if (d_rise_i) state_d = ST_MARK;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pend_v_q <= 1'b0;
      pend_b_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SHIFT && ck_rise_i) begin
        pend_v_q <= 1'b1;
        pend_b_q <= d_lvl_i;
      end else if (ck_fall_i || state_d != ST_SHIFT) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign active_o = (state_q == ST_SHIFT) || (state_q == ST_MARK) ||
                    (state_q == ST_FIN);
  assign idle_o   = (state_q == ST_IDLE);

  // R7: a stalled serial clock forces the sequencer back to idle
  a_r7_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_timeout |=> (state_q == ST_IDLE));
  // R6: commit only follows a full stop marker
  a_r6_commit_from_fin: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> ($past(state_q) == ST_MARK || state_q == ST_FIN) && !idle_o);
endmodule

// File: rtl/cfgl_shift_reg.sv
module cfgl_shift_reg #(
  parameter int               REG_W       = 20,
  parameter logic [REG_W-1:0] DEFAULT_CFG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             take_i,
  input  logic             bit_i,
  input  logic             commit_i,
  output logic [REG_W-1:0] cfg_o
);
  localparam int CNT_W = $clog2(REG_W + 1);

  logic [REG_W-1:0] sh_q, cfg_q, mask_w;
  logic [CNT_W-1:0] cnt_q;

  // Ones in the n lowest positions.
  function automatic logic [REG_W-1:0] low_mask(input logic [CNT_W-1:0] n);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (n > CNT_W'(i));
    return m;
  endfunction

  assign mask_w = low_mask(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      cfg_q <= DEFAULT_CFG;
    end else begin
      if (clear_i) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (take_i) begin
        sh_q <= {sh_q[REG_W-2:0], bit_i};
        if (cnt_q != CNT_W'(REG_W)) cnt_q <= cnt_q + 1'b1;
      end
      if (commit_i) cfg_q <= (cfg_q & ~mask_w) | (sh_q & mask_w);
    end
  end

  assign cfg_o = cfg_q;

  // R5: bits above the received length survive a commit
  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (((cfg_q ^ $past(cfg_q)) & ~$past(mask_w)) == '0));
  // R6: the register moves only on a commit
  a_r6_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(commit_i));
  // R8: bit count saturates at the register width
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(REG_W));
endmodule

// File: rtl/cfg_pin_loader.sv
module cfg_pin_loader #(
  parameter int          REG_W       = 20,
  parameter logic [19:0] DEFAULT_CFG = 20'h5A5A5,
  parameter int          CLK_HZ      = 50_000_000,
  parameter int          IDLE_US     = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_pin_i,
  input  logic             sdat_pin_i,
  output logic             sdat_oe_o,
  output logic             prog_active_o,
  output logic [REG_W-1:0] cfg_o
);
  localparam int TIMEOUT_CYC = (CLK_HZ / 1_000_000) * IDLE_US;

  logic [1:0] lvl, rise, fall;
  logic take, take_bit, clear, commit, active, idle;

  cfgl_pin_sync #(.N_LINES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_i({sdat_pin_i, sclk_pin_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  cfgl_seq_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .ck_lvl_i(lvl[0]), .ck_rise_i(rise[0]), .ck_fall_i(fall[0]),
    .d_lvl_i(lvl[1]), .d_rise_i(rise[1]), .d_fall_i(fall[1]),
    .take_o(take), .take_bit_o(take_bit), .clear_o(clear),
    .commit_o(commit), .active_o(active), .idle_o(idle)
  );

  cfgl_shift_reg #(.REG_W(REG_W), .DEFAULT_CFG(REG_W'(DEFAULT_CFG))) dp_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .take_i(take),
    .bit_i(take_bit), .commit_i(commit), .cfg_o(cfg_o)
  );

  assign sdat_oe_o     = idle & ~lvl[0];
  assign prog_active_o = active;

  // R2: pad released once the serial clock has been high for a while
  a_r2_oe_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_pin_i && $past(sclk_pin_i) && $past(sclk_pin_i, 2)) |-> !sdat_oe_o);
  // R2: pad never driven during a transfer
  a_r2_active_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    prog_active_o |-> !sdat_oe_o);
endmodule

// File: tb/cfg_pin_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_pin_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic sdat = 1'b0;
  logic oe, act;
  logic [19:0] cfg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_pin_loader dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_pin_i(sclk), .sdat_pin_i(sdat),
    .sdat_oe_o(oe), .prog_active_o(act), .cfg_o(cfg)
  );

  // {bit count[44:40], data[39:20], expected register[19:0]}
  localparam logic [44:0] VEC [8] = '{
    {5'd20, 20'hC3A71, 20'hC3A71},
    {5'd3,  20'h00002, 20'hC3A72},
    {5'd8,  20'h000FF, 20'hC3AFF},
    {5'd20, 20'h00000, 20'h00000},
    {5'd1,  20'h00001, 20'h00001},
    {5'd12, 20'h00ABC, 20'h00ABC},
    {5'd20, 20'hFFFFF, 20'hFFFFF},
    {5'd0,  20'h00000, 20'hFFFFF}
  };

  task automatic chk(input string req, input logic [31:0] actv, input logic [31:0] expv);
    checks++;
    if (actv !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, actv, expv);
    end
  endtask

  task automatic wt;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_start;
    sclk = 1'b1; wt(); sdat = 1'b0; wt();
    sclk = 1'b0; wt(); sclk = 1'b1; wt();
    sdat = 1'b1; wt(); sdat = 1'b0; wt();
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b0; wt(); sdat = b; wt(); sclk = 1'b1; wt();
  endtask

  task automatic send_stop;
    sclk = 1'b0; wt(); sdat = 1'b0; wt(); sclk = 1'b1; wt();
    sdat = 1'b1; wt(); sdat = 1'b0; wt(); sclk = 1'b0; wt();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] prev;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wt();
    chk("R1 cfg default", 32'(cfg), 32'h5A5A5);
    chk("R1 active low", 32'(act), 0);
    chk("R1 oe high", 32'(oe), 1);

    sclk = 1'b1; wt();
    chk("R2 oe off clk high", 32'(oe), 0);
    sclk = 1'b0; wt();
    chk("R2 oe back clk low", 32'(oe), 1);

    // R9: clock drops in the middle of the start pulse
    sclk = 1'b1; wt(); sdat = 1'b0; wt(); sclk = 1'b0; wt(); sclk = 1'b1; wt();
    sdat = 1'b1; wt(); sclk = 1'b0; wt(); sdat = 1'b0; wt();
    chk("R9 no start", 32'(act), 0);
    chk("R9 oe restored", 32'(oe), 1);
    chk("R9 cfg kept", 32'(cfg), 32'h5A5A5);

    prev = 20'h5A5A5;
    for (int v = 0; v < 8; v++) begin
      int n;
      n = int'(VEC[v][44:40]);
      send_start();
      chk("R3 active after start", 32'(act), 1);
      for (int i = n - 1; i >= 0; i--) send_bit(VEC[v][20 + i]);
      sclk = 1'b0; wt();
      chk("R2 oe off in transfer", 32'(oe), 0);
      chk("R6 no early commit", 32'(cfg), 32'(prev));
      send_stop();
      chk((n == 20) ? "R4 full load" : "R5 partial load", 32'(cfg), 32'(VEC[v][19:0]));
      chk("R6 active cleared", 32'(act), 0);
      chk("R6 oe restored", 32'(oe), 1);
      prev = VEC[v][19:0];
    end

    // R8: 24 bits, last 20 kept
    send_start();
    for (int i = 23; i >= 0; i--) send_bit(24'h912345 >> i);
    send_stop();
    chk("R8 overlong keeps last bits", 32'(cfg), 32'h12345);

    // R7: stall serial clock mid transfer
    send_start();
    for (int i = 4; i >= 0; i--) send_bit(5'b10101 >> i);
    repeat (10100) @(negedge clk);
    chk("R7 timeout drops transfer", 32'(act), 0);
    sclk = 1'b0; wt();
    chk("R7 oe after timeout", 32'(oe), 1);
    send_stop();
    chk("R7 cfg unchanged", 32'(cfg), 32'h12345);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule